// File: doc/BRIEF.md
# Pipelined FIR Multiply-Accumulate Engine

This block is a fixed-point convolution engine for a stream of signed samples. Each accepted sample goes into a circular history buffer that holds the latest TAPS samples. The engine then walks the whole tap vector. In each clock it reads one constant coefficient from a read-only coefficient store and one sample from the history buffer, and it folds their product into a wide accumulator. The result is the dot product of the coefficient vector with the sample history. The newest sample pairs with tap 0.

The engine handles one sample at a time. `in_ready` goes low once a sample is taken and rises again when that sample's result leaves the block. The result is a signed word clamped to the output width, qualified by a one-cycle `out_valid` pulse. The coefficient store is built at elaboration time. Tap k is k+1 when k is even and -(k+1) when k is odd.

Top module: `fir_mac_engine`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. From that edge until its result appears, `in_ready` stays 0, and any `in_valid` offered in that time has no effect on any later result.
- R3: Each result equals sum over k = 0..TAPS-1 of h[k] * x[k], where x[0] is the sample just taken and x[k] is the one taken k samples before it.
- R4: The coefficients are h[k] = k+1 for even k and -(k+1) for odd k. A single sample of value 1 followed by zeros, on a history that is otherwise zero, yields h[0], h[1], ..., h[TAPS-1] on successive results.
- R5: History positions not yet filled since reset count as zero in the sum.
- R6: A sum above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1, and a sum below -2^(OUT_W-1) is output as -2^(OUT_W-1). Results never wrap.
- R7: Exactly one `out_valid` pulse follows each accepted sample, TAPS+3 rising edges after the accepting edge. `in_ready` is 1 in the same cycle as that pulse.
- R8: A partial sum that leaves the output range during the tap walk does not disturb a final sum that lies inside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Signed clamped dot product |

## Verification
A wrong write pointer or a wrong read-pointer decrement pairs samples with the wrong taps. This shows in the first result that follows the impulse, and it persists in every later result of a varied stream. A stale fill count or a missing accumulator clear changes the very first results after reset, or the first result that follows a large one. A control-sequencing fault moves the `out_valid` pulse away from its TAPS+3 position, or leaves `in_ready` low, and the next sample exposes this.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

  // Issue tag that travels with each tap through the pipeline
  typedef struct packed {
    logic vld;    // a tap is in flight
    logic first;  // tap 0: accumulator restarts
    logic last;   // final tap of this dot product
    logic zero;   // history slot not yet filled since reset
  } fir_tag_t;

  // Constant tap vector: even taps positive, odd taps negative
  function automatic int tap_coef(input int k);
    return (k % 2 == 0) ? (k + 1) : -(k + 1);
  endfunction

endpackage

// File: rtl/fir_sample_ram.sv
module fir_sample_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom
  import fir_mac_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [COEF_W-1:0] q
);

  logic [COEF_W-1:0] rom [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
      assign rom[i] = COEF_W'(tap_coef(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    q <= rom[addr];
  end

endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_mac_pkg::*;
#(
  parameter int TAPS  = 8,
  localparam int PW   = $clog2(TAPS),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          acc_done,
  output logic          in_ready,
  output logic          we,
  output logic [PW-1:0] waddr,
  output logic [PW-1:0] raddr,
  output logic [PW-1:0] caddr,
  output fir_tag_t      tag
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  localparam logic [PW-1:0] LAST_K = PW'(TAPS - 1);
  localparam logic [CW-1:0] FULL   = CW'(TAPS);

  state_t        state;
  logic [PW-1:0] wr_ptr, rd_ptr, tap_k;
  logic [CW-1:0] fill;
  logic          take;

  assign in_ready = (state == S_IDLE);
  assign take     = in_valid && in_ready;
  assign we       = take;
  assign waddr    = wr_ptr;
  assign raddr    = rd_ptr;
  assign caddr    = tap_k;

  always_comb begin
    tag       = '0;
    tag.vld   = (state == S_RUN);
    tag.first = (state == S_RUN) && (tap_k == '0);
    tag.last  = (state == S_RUN) && (tap_k == LAST_K);
    tag.zero  = ({1'b0, tap_k} >= fill);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      wr_ptr <= '0;
      rd_ptr <= '0;
      tap_k  <= '0;
      fill   <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          rd_ptr <= wr_ptr;
          wr_ptr <= (wr_ptr == LAST_K) ? '0 : wr_ptr + 1'b1;
          tap_k  <= '0;
          if (fill != FULL) fill <= fill + 1'b1;
          state  <= S_RUN;
        end
        S_RUN: begin
          rd_ptr <= (rd_ptr == '0) ? LAST_K : rd_ptr - 1'b1;
          tap_k  <= tap_k + 1'b1;
          if (tap_k == LAST_K) state <= S_DRAIN;
        end
        S_DRAIN: if (acc_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fir_mac_dp.sv
module fir_mac_dp
  import fir_mac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int GUARD_W = 8,
  parameter int OUT_W  = 16,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  fir_tag_t          tag_i,
  input  logic [DATA_W-1:0] smp_q,
  input  logic [COEF_W-1:0] coef_q,
  output logic              acc_done,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);

  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  fir_tag_t                 s1_tag, s2_tag;
  logic signed [DATA_W-1:0] opnd_x;
  logic signed [COEF_W-1:0] opnd_h;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, prod_ext, acc_base;
  logic                     s3_last;

  // Stage 1: tag aligned with the registered memory outputs
  always_ff @(posedge clk) begin
    if (rst) s1_tag <= '0;
    else     s1_tag <= tag_i;
  end

  assign opnd_x = s1_tag.zero ? '0 : $signed(smp_q);
  assign opnd_h = $signed(coef_q);

  // Stage 2: product register
  always_ff @(posedge clk) begin
    if (rst) s2_tag <= '0;
    else     s2_tag <= s1_tag;
    prod <= opnd_x * opnd_h;
  end

  assign prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
  assign acc_base = s2_tag.first ? '0 : acc;

  // Stage 3: guard-bit accumulator, cleared on the first tap
  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      s3_last <= 1'b0;
    end else begin
      if (s2_tag.vld) acc <= acc_base + prod_ext;
      s3_last <= s2_tag.vld && s2_tag.last;
    end
  end

  assign acc_done = s3_last;

  // Stage 4: clamp to output width, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s3_last;
      if (s3_last) begin
        if (acc > SAT_HI)      out_data <= SAT_HI[OUT_W-1:0];
        else if (acc < SAT_LO) out_data <= SAT_LO[OUT_W-1:0];
        else                   out_data <= acc[OUT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int TAPS    = 8,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int GUARD_W = 8,
  parameter int OUT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);

  localparam int PW = $clog2(TAPS);

  logic              we, acc_done;
  logic [PW-1:0]     waddr, raddr, caddr;
  logic [DATA_W-1:0] smp_q;
  logic [COEF_W-1:0] coef_q;
  fir_tag_t          tag;

  fir_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_done(acc_done),
    .in_ready(in_ready), .we(we), .waddr(waddr), .raddr(raddr),
    .caddr(caddr), .tag(tag)
  );

  fir_sample_ram #(.DATA_W(DATA_W), .DEPTH(TAPS)) u_hist (
    .clk(clk), .we(we), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(smp_q)
  );

  fir_coef_rom #(.COEF_W(COEF_W), .DEPTH(TAPS)) u_coef (
    .clk(clk), .addr(caddr), .q(coef_q)
  );

  fir_mac_dp #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .GUARD_W(GUARD_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .tag_i(tag), .smp_q(smp_q), .coef_q(coef_q),
    .acc_done(acc_done), .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
  parameter int TAPS = 8
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid
);

  localparam int LW = $clog2(TAPS + 8);

  logic          pending;
  logic [LW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      since   <= '0;
    end else begin
      if (pending) since <= since + 1'b1;
      if (out_valid) pending <= 1'b0;
      if (in_valid && in_ready) begin
        pending <= 1'b1;
        since   <= '0;
      end
    end
  end

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_ready_with_result_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  assert_result_latency_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pending && since == LW'(TAPS + 3)));

  assert_no_take_while_pending_R2: assert property (@(posedge clk) disable iff (rst)
    (pending && !out_valid) |-> !in_ready);

endmodule

bind fir_mac_engine fir_mac_engine_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid)
);

// File: tb/fir_mac_engine_bench.sv
module fir_mac_engine_bench;

  localparam int TAPS  = 8;
  localparam int DW    = 16;
  localparam int OW    = 16;
  localparam longint OMAX = (64'sd1 <<< (OW - 1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (OW - 1));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  always #2ns clk = ~clk;

  fir_mac_engine #(.TAPS(TAPS), .DATA_W(DW), .OUT_W(OW)) u_fir_mac_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct {
    longint val;
    int     t_take;
    string  req;
  } exp_t;

  exp_t   sb[$];
  longint hist [TAPS];
  int     cyc = 0;
  int     n_chk = 0;
  int     n_fail = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint h_of(int k);
    return (k % 2 == 0) ? longint'(k + 1) : -longint'(k + 1);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: offer one sample, push the model's expected result
  task automatic send(int s, string req);
    longint sum;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(s);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(s);
    sum = 0;
    for (int k = 0; k < TAPS; k++) sum += h_of(k) * hist[k];
    if (sum > OMAX) sum = OMAX;
    if (sum < OMIN) sum = OMIN;
    sb.push_back('{val: sum, t_take: cyc + 1, req: req});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Offer junk while the engine is busy (R2: must be ignored)
  task automatic poke_busy(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (in_ready) break;
      in_valid = 1'b1;
      in_data  = DW'(16'h5A5A + i);
    end
    in_valid = 1'b0;
  endtask

  // Monitor: pop and compare on every result strobe
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7 unexpected result", longint'($signed(out_data)), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(longint'($signed(out_data)) == e.val, e.req,
              longint'($signed(out_data)), e.val);
        check(cyc - e.t_take == TAPS + 3, "R7 latency",
              cyc - e.t_take, TAPS + 3);
        check(in_ready == 1'b1, "R7 ready with result", in_ready, 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lcg;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);

    // R5 + R4: impulse on an empty history
    send(1, "R5 impulse first result");
    for (int k = 1; k < TAPS; k++) send(0, "R4 impulse response");
    for (int k = 0; k < 2; k++) send(0, "R4 tail zero");

    // R3: varied stream with mixed signs
    lcg = 12345;
    for (int i = 0; i < 14; i++) begin
      lcg = (lcg * 1103 + 4421) % 65536;
      send(lcg - 32768 >>> 4, "R3 stream");
    end

    // R2: junk offered while busy must not enter the history
    for (int i = 0; i < 4; i++) begin
      send(100 * (i + 1) - 250, "R2 ignored while busy");
      poke_busy(TAPS + 6);
    end

    // R6: positive then negative clamping
    for (int i = 0; i < TAPS; i++)
      send((i % 2 == 0) ? -32768 : 32767, "R6 positive clamp");
    for (int i = 0; i < TAPS; i++) send(32767, "R6 negative clamp");

    // R8: partial sums leave the output range, final sum is zero
    for (int i = 0; i < TAPS; i++)
      send((i % 2 == 0) ? 4800 : 6000, "R8 guard bits");

    // Back-to-back offers for R7
    for (int i = 0; i < 6; i++) send(i * 7 - 20, "R7 back-to-back");

    for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, "R7 all results seen", sb.size(), 0);
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule